// File: doc/BRIEF.md
# Buffered Input Capture Channel

This block is one input-capture channel of a timer. It watches an external pin, and on a qualified edge it records the value of a free-running timer count. A host reads the recorded value later. The result lands in a capture register. A second holding register sits behind it, so two timestamps can wait for the host at once.

The holding register is filled in one of two ways, chosen by a mode bit. In latch mode, the capture value is moved to the holding register on an external trigger. The triggers are a modulus-counter underflow pulse, a modulus-counter write-zero pulse and a software latch strobe. In queue mode, each new capture pushes the older value into the holding register, so the two registers form a two-entry FIFO. A no-overwrite bit decides whether unread data may be replaced or must be kept. Each register has a full flag that the host clears by reading.

Top module: `buf_capture_chan`

## Requirements
- R1: The pin passes through two synchronizer flops and one edge-history flop. A pin change driven before clock edge k is captured at edge k+2. The capture stores the timer count present at that edge, and `cap_evt` is high for the one cycle that follows edge k+2.
- R2: `edge_sel` qualifies edges with this encoding: 2'b00 no edges, 2'b01 rising only, 2'b10 falling only, 2'b11 both.
- R3: With `no_ovw` low, every qualified edge writes the capture register, whether or not its old value was read.
- R4: With `no_ovw` high, a qualified edge that finds the capture register full is dropped and raises no `cap_evt`, unless the old value leaves the capture register in the same cycle.
- R5: In latch mode (`latch_mode`=1), any of `sw_latch`, `mod_zero` or `mod_wr_zero` moves a full capture register into the holding register. This sets `hold_full` and clears `cap_full`. A trigger that finds the capture register empty changes nothing.
- R6: In latch mode with `no_ovw` high, a latch trigger that finds the holding register full is blocked, and both registers keep their values.
- R7: In latch mode with `no_ovw` low, a latch trigger overwrites a full holding register.
- R8: In queue mode (`latch_mode`=0), a qualified edge that finds the capture register full first moves the old value into the holding register and then stores the new count. A capture into an empty capture register leaves the holding register alone. The latch triggers have no effect in this mode.
- R9: In queue mode with `no_ovw` high and both registers full, a qualified edge is dropped and both registers keep their values.
- R10: A register's full flag is set when the register is written and cleared by its read strobe (`rd_cap`, `rd_hold`). A read in the same cycle as a write leaves the flag set, with the new data.
- R11: When a capture and a latch trigger fall in the same cycle, the old capture value goes to the holding register and the new count goes to the capture register.
- R12: After reset, both data registers read zero, both full flags are clear and `cap_evt` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_cnt | input | TW | Free-running timer count |
| pin_in | input | 1 | Asynchronous capture pin |
| edge_sel | input | 2 | Edge qualifier (see R2) |
| latch_mode | input | 1 | 1 = latch mode, 0 = queue mode |
| no_ovw | input | 1 | Protect unread data |
| sw_latch | input | 1 | Software latch strobe |
| mod_zero | input | 1 | Modulus counter reached zero |
| mod_wr_zero | input | 1 | Zero written to modulus counter |
| rd_cap | input | 1 | Host read of capture register |
| rd_hold | input | 1 | Host read of holding register |
| cap_val | output | TW | Capture register |
| hold_val | output | TW | Holding register |
| cap_full | output | 1 | Capture register holds unread data |
| hold_full | output | 1 | Holding register holds unread data |
| cap_evt | output | 1 | One-cycle pulse per stored capture |

## Verification
A pin change takes effect three rising edges after the falling edge on which it is driven: two synchronizer edges and then the capture edge. A read strobe or latch trigger takes effect on the first rising edge after it is driven. The bench drives every input on a falling edge and checks on the falling edge just after the rising edge where the result is due. The same-cycle cases of R10 and R11 are built by raising the strobe two cycles after the pin change, so that the strobe meets the capture edge. The latency test of R1 also samples the two cycles before the capture edge to confirm that nothing arrives early.

// File: rtl/buf_capture_chan.sv
module buf_capture_chan #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] timer_cnt,
  input  logic          pin_in,
  input  logic [1:0]    edge_sel,
  input  logic          latch_mode,
  input  logic          no_ovw,
  input  logic          sw_latch,
  input  logic          mod_zero,
  input  logic          mod_wr_zero,
  input  logic          rd_cap,
  input  logic          rd_hold,
  output logic [TW-1:0] cap_val,
  output logic [TW-1:0] hold_val,
  output logic          cap_full,
  output logic          hold_full,
  output logic          cap_evt
);

  logic [2:0] pin_q;
  logic       rise, fall, hit, lat_req, can_move, move, cap_wr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_q <= '0;
    else        pin_q <= {pin_q[1:0], pin_in};

  assign rise     = pin_q[1] & ~pin_q[2];
  assign fall     = ~pin_q[1] & pin_q[2];
  assign hit      = (edge_sel[0] & rise) | (edge_sel[1] & fall);
  assign lat_req  = latch_mode & (sw_latch | mod_zero | mod_wr_zero);
  assign can_move = cap_full & (~no_ovw | ~hold_full);
  assign move     = can_move & (latch_mode ? lat_req : hit);
  assign cap_wr   = hit & (~no_ovw | ~cap_full | move);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cap_val   <= '0;
      hold_val  <= '0;
      cap_full  <= 1'b0;
      hold_full <= 1'b0;
      cap_evt   <= 1'b0;
    end else begin
      cap_evt <= cap_wr;
      if (move)    hold_val <= cap_val;
      if (cap_wr)  cap_val  <= timer_cnt;
      if (cap_wr)              cap_full <= 1'b1;
      else if (move | rd_cap)  cap_full <= 1'b0;
      if (move)         hold_full <= 1'b1;
      else if (rd_hold) hold_full <= 1'b0;
    end

  AST_EVT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> cap_full); // R10
  AST_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
    (!no_ovw && hit) |=> (cap_evt && cap_val == $past(timer_cnt))); // R3
  AST_CAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (no_ovw && cap_full && hold_full && !rd_cap) |=> ($stable(cap_val) && cap_full)); // R9
  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (no_ovw && hold_full) |=> $stable(hold_val)); // R6
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cap && edge_sel == 2'b00) |=> !cap_full); // R10
  AST_QUEUE_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_mode && edge_sel == 2'b00) |=> $stable(hold_val)); // R8

endmodule

// File: tb/sim_buf_capture_chan.sv
module sim_buf_capture_chan;
  logic clk = 0, rst_n = 0;
  logic [15:0] timer_cnt = '0;
  logic pin_in = 0, latch_mode = 0, no_ovw = 0;
  logic [1:0] edge_sel = 2'b11;
  logic sw_latch = 0, mod_zero = 0, mod_wr_zero = 0, rd_cap = 0, rd_hold = 0;
  logic [15:0] cap_val, hold_val;
  logic cap_full, hold_full, cap_evt;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  buf_capture_chan #(.TW(16)) u0 (.*);

  localparam int SL = 0, MZ = 1, WZ = 2, RC = 3, RH = 4;

  // {toggle, rd_cap, rd_hold, timer, exp_cap, exp_hold, exp_cf, exp_hf}
  localparam int NV = 8;
  localparam logic [52:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,16'h1111,16'h1111,16'h0000,1'b1,1'b0},
    {1'b1,1'b0,1'b0,16'h2222,16'h2222,16'h1111,1'b1,1'b1},
    {1'b1,1'b0,1'b0,16'h3333,16'h3333,16'h2222,1'b1,1'b1},
    {1'b0,1'b0,1'b1,16'h0000,16'h3333,16'h2222,1'b1,1'b0},
    {1'b0,1'b1,1'b0,16'h0000,16'h3333,16'h2222,1'b0,1'b0},
    {1'b1,1'b0,1'b0,16'h4444,16'h4444,16'h2222,1'b1,1'b0},
    {1'b1,1'b0,1'b0,16'h5555,16'h5555,16'h4444,1'b1,1'b1},
    {1'b0,1'b1,1'b1,16'h0000,16'h5555,16'h4444,1'b0,1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_str(input logic [4:0] m);
    sw_latch = m[SL]; mod_zero = m[MZ]; mod_wr_zero = m[WZ]; rd_cap = m[RC]; rd_hold = m[RH];
  endtask

  task automatic strobe(input logic [4:0] m);
    @(negedge clk); set_str(m);
    @(negedge clk); set_str('0);
  endtask

  task automatic fire(input logic [15:0] tv, input logic lvl, input logic [4:0] late);
    @(negedge clk); timer_cnt = tv; pin_in = lvl;
    @(negedge clk);
    @(negedge clk); set_str(late);
    @(negedge clk); set_str('0);
  endtask

  task automatic do_reset();
    @(negedge clk); pin_in = 0; rst_n = 0; set_str('0);
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic regs(input string req, input logic [15:0] c, input logic [15:0] h,
                      input logic cf, input logic hf);
    chk(req, cap_val, c); chk(req, hold_val, h);
    chk(req, {15'd0, cap_full}, {15'd0, cf}); chk(req, {15'd0, hold_full}, {15'd0, hf});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    regs("R12", 16'h0, 16'h0, 0, 0);
    chk("R12", {15'd0, cap_evt}, 16'd0);

    // queue mode table, no_ovw clear, both edges (R8, R3, R10)
    for (int i = 0; i < NV; i++) begin
      logic [52:0] v;
      v = VEC[i];
      if (v[52]) fire(v[49:34], ~pin_in, '0);
      else       strobe({v[50], v[51], 3'b000});
      regs($sformatf("R8 row%0d", i), v[33:18], v[17:2], v[1], v[0]);
    end

    // R1 latency and R2 edge select
    do_reset();
    edge_sel = 2'b01; latch_mode = 0; no_ovw = 0;
    @(negedge clk); timer_cnt = 16'h7777; pin_in = 1;
    @(negedge clk); chk("R1 early", {15'd0, cap_full}, 16'd0);
    @(negedge clk); chk("R1 early", {15'd0, cap_full}, 16'd0);
    @(negedge clk); chk("R1 due", cap_val, 16'h7777); chk("R1 evt", {15'd0, cap_evt}, 16'd1);
    @(negedge clk); chk("R1 evt end", {15'd0, cap_evt}, 16'd0);
    fire(16'h1111, 0, '0); chk("R2 rise only", cap_val, 16'h7777);
    edge_sel = 2'b10;
    fire(16'h2222, 1, '0); chk("R2 fall only", cap_val, 16'h7777);
    fire(16'h3333, 0, '0); chk("R2 fall", cap_val, 16'h3333);
    edge_sel = 2'b00;
    fire(16'h4444, 1, '0); chk("R2 off", cap_val, 16'h3333);
    edge_sel = 2'b11;
    fire(16'h5555, 0, '0); chk("R2 both", cap_val, 16'h5555);
    fire(16'h6666, 1, '0); chk("R2 both", cap_val, 16'h6666);

    // latch mode
    do_reset();
    latch_mode = 1; no_ovw = 1; edge_sel = 2'b11;
    fire(16'hA0A0, 1, '0);
    strobe(5'b1 << SL); regs("R5 sw", 16'hA0A0, 16'hA0A0, 0, 1);
    fire(16'hB0B0, 0, '0);
    strobe(5'b1 << MZ); regs("R6 blocked", 16'hB0B0, 16'hA0A0, 1, 1);
    fire(16'hC0C0, 1, '0);
    chk("R4 drop", cap_val, 16'hB0B0); chk("R4 no evt", {15'd0, cap_evt}, 16'd0);
    strobe(5'b1 << RH);
    strobe(5'b1 << WZ); regs("R5 wz", 16'hB0B0, 16'hB0B0, 0, 1);
    strobe(5'b1 << RH);
    strobe(5'b1 << SL); regs("R5 empty", 16'hB0B0, 16'hB0B0, 0, 0);
    no_ovw = 0;
    fire(16'hD0D0, 0, '0);
    fire(16'hD1D1, 1, '0); chk("R3 overwrite", cap_val, 16'hD1D1);
    strobe(5'b1 << SL);
    fire(16'hE0E0, 0, '0);
    strobe(5'b1 << MZ); regs("R7 overwrite", 16'hE0E0, 16'hE0E0, 0, 1);
    fire(16'hF0F0, 1, '0);
    fire(16'hF1F1, 0, 5'b1 << SL); regs("R11 same cycle", 16'hF1F1, 16'hF0F0, 1, 1);
    strobe(5'b1 << RC);
    fire(16'hF2F2, 1, 5'b1 << RC); regs("R10 rd+wr", 16'hF2F2, 16'hF0F0, 1, 1);
    strobe(5'b1 << RC); chk("R10 read", {15'd0, cap_full}, 16'd0);

    // queue mode with protection
    latch_mode = 0;
    strobe(5'b00111); regs("R8 latch ignored", 16'hF2F2, 16'hF0F0, 0, 1);
    no_ovw = 1;
    fire(16'h1234, 0, '0); regs("R8 empty cap", 16'h1234, 16'hF0F0, 1, 1);
    fire(16'h5678, 1, '0); regs("R9 drop", 16'h1234, 16'hF0F0, 1, 1);
    chk("R9 no evt", {15'd0, cap_evt}, 16'd0);
    strobe(5'b1 << RH);
    fire(16'h9ABC, 0, '0); regs("R8 shift", 16'h9ABC, 16'h1234, 1, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule